// File: doc/BRIEF.md
# Receive Overrun Statistics Counters

This block watches the receive side of an Ethernet MAC and classifies every received frame by whether the receiver ran out of resources while taking it in, and if so, when and why. Two resources are watched. One is the cell FIFO, which is either full or not. The other is the DMA buffer supply, which is available when the head descriptor pointer is non-zero. A frame whose first cycle finds either resource missing is a start-phase overrun. A frame that starts cleanly but loses a resource later, up to and including its last cycle, is a middle-phase overrun.

Three statistics counters are kept: start-phase overruns, middle-phase overruns, and overruns of either phase in which the DMA buffer was one of the missing resources. A frame counts only if it passed address matching, and the matcher's verdict is sampled on the frame's end strobe. Frame length and line error status play no part in the decision.

Software reads the counters through a small register port. Writing to a counter clears it.

Top module: `rx_ovr_stats`

## Requirements
- R1: After reset, all three counters read zero.
- R2: A frame updates no counter unless `frm_match` is 1 in the cycle that `frm_eof` is 1.
- R3: A frame whose first cycle (`frm_sof`=1) has `fifo_full`=1 or `dma_avail`=0 adds one to the start-overrun counter.
- R4: A frame whose first cycle has both resources adds one to the middle-overrun counter if some later cycle, up to and including its `frm_eof` cycle, has `fifo_full`=1 or `dma_avail`=0. A frame never adds to both the start-overrun and middle-overrun counters.
- R5: The DMA-overrun counter gains one for a counted overrun frame whose first overrun cycle has `dma_avail`=0. Overruns caused by the FIFO alone leave it unchanged, and so does any resource loss after the first overrun.
- R6: If `fifo_full`=1 and `dma_avail`=0 in the same first overrun cycle, the frame adds one to its phase counter and one to the DMA-overrun counter.
- R7: The error bits `frm_err` (bit 0 CRC, bit 1 alignment, bit 2 code) and the frame length (including single-cycle frames) have no effect on any counter.
- R8: Each counter changes at most once per frame, in the clock edge that ends the `frm_eof` cycle. A frame without an overrun changes nothing.
- R9: Counters wrap from all-ones to zero.
- R10: `reg_addr` 0, 1 and 2 select the start, middle and DMA counters on `reg_rdata`, and address 3 reads zero. `reg_wr`=1 clears the addressed counter whatever `reg_wdata` holds, and a clear wins over an increment in the same cycle.
- R11: A `frm_sof` that arrives while a frame is open drops the open frame's tracking without counting it. If `frm_sof` and `frm_eof` are 1 together, they form a one-cycle frame.
- R12: A `frm_eof` with no open frame and no `frm_sof` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_sof | input | 1 | First cycle of a received frame |
| frm_eof | input | 1 | Last cycle of a received frame |
| frm_match | input | 1 | Address match verdict, sampled with `frm_eof` |
| frm_err | input | 3 | CRC, alignment and code error flags (not used) |
| fifo_full | input | 1 | Cell FIFO has no room |
| dma_avail | input | 1 | Head descriptor pointer is non-zero |
| reg_addr | input | 2 | Counter select |
| reg_wr | input | 1 | Clear the addressed counter |
| reg_wdata | input | CNT_W | Write data (value not used) |
| reg_rdata | output | CNT_W | Selected counter value |

## Verification
The assertions check several rules on every cycle. A single frame never reaches both phase counters. Increments happen only on a matched end strobe. A DMA count always comes with a phase count. Each counter clears, steps by one or holds, and a clear beats an increment. Other behaviour only shows up across a whole frame, so the bench's scenarios are needed for it:
- sorting a frame by the cycle in which resources first ran out;
- the first cause winning over later losses;
- aborting a frame on a repeated start;
- ignoring a stray end strobe;
- wrap-around and the read map.

// File: rtl/rx_ovr_pkg.sv
package rx_ovr_pkg;
   localparam int NUM_CNT = 3;
   localparam int ADDR_W  = 2;
   localparam int IDX_SOF = 0;
   localparam int IDX_MOF = 1;
   localparam int IDX_DMA = 2;
   localparam int ERR_W   = 3;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_RECV = 2'd1,
      PH_DROP_SOF = 2'd2,
      PH_DROP_MOF = 2'd3
   } phase_e;

   typedef struct packed {
      logic sof;
      logic mof;
      logic dma;
   } ovr_inc_t;
endpackage

// File: rtl/rx_ovr_tracker.sv
module rx_ovr_tracker
   import rx_ovr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     frm_sof,
   input  logic     frm_eof,
   input  logic     frm_match,
   input  logic     fifo_full,
   input  logic     dma_avail,
   output ovr_inc_t inc
);
   phase_e ph_q, ph_now;
   logic   dma_q, dma_now;
   logic   lack;
   logic   active;

   assign lack = fifo_full | ~dma_avail;

   always_comb begin
      ph_now  = ph_q;
      dma_now = dma_q;
      if (frm_sof) begin
         ph_now  = lack ? PH_DROP_SOF : PH_RECV;
         dma_now = ~dma_avail;
      end else if (ph_q == PH_RECV && lack) begin
         ph_now  = PH_DROP_MOF;
         dma_now = ~dma_avail;
      end
   end

   assign active = frm_sof | (ph_q != PH_IDLE);

   always_comb begin
      inc = '0;
      if (active && frm_eof && frm_match) begin
         inc.sof = (ph_now == PH_DROP_SOF);
         inc.mof = (ph_now == PH_DROP_MOF);
         inc.dma = dma_now && (ph_now != PH_RECV);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         dma_q <= 1'b0;
      end else if (active && frm_eof) begin
         ph_q  <= PH_IDLE;
         dma_q <= 1'b0;
      end else if (active) begin
         ph_q  <= ph_now;
         dma_q <= dma_now;
      end
   end

   AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      !(inc.sof && inc.mof)); // R4
   AST_INC_ON_MATCHED_END: assert property (@(posedge clk) disable iff (!rst_n)
      (inc.sof || inc.mof || inc.dma) |-> (frm_eof && frm_match)); // R2
   AST_DMA_HAS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      inc.dma |-> (inc.sof || inc.mof)); // R5
   AST_IDLE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      frm_eof |=> (ph_q == PH_IDLE)); // R8
endmodule

// File: rtl/rx_ovr_counter.sv
module rx_ovr_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   output logic [CNT_W-1:0] q
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= '0;
      else if (inc) q <= q + ONE;
   end

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q == '0)); // R10
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr) |=> (q == $past(q) + ONE)); // R9
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !clr) |=> $stable(q)); // R8
endmodule

// File: rtl/rx_ovr_regport.sv
module rx_ovr_regport
   import rx_ovr_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter bit RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [CNT_W-1:0]  cnt [NUM_CNT],
   output logic [NUM_CNT-1:0] clr,
   output logic [CNT_W-1:0]  reg_rdata
);
   logic [CNT_W-1:0] sel;

   always_comb begin
      sel = '0;
      for (int i = 0; i < NUM_CNT; i++)
         if (int'(reg_addr) == i) sel = cnt[i];
   end

   genvar g;
   generate
      for (g = 0; g < NUM_CNT; g++) begin : g_clr
         assign clr[g] = reg_wr && (int'(reg_addr) == g);
      end
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) reg_rdata <= '0;
            else        reg_rdata <= sel;
         end
      end else begin : g_rd_comb
         assign reg_rdata = sel;
      end
   endgenerate

   AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr)); // R10
endmodule

// File: rtl/rx_ovr_stats.sv
module rx_ovr_stats
   import rx_ovr_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter bit RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_sof,
   input  logic              frm_eof,
   input  logic              frm_match,
   input  logic [ERR_W-1:0]  frm_err,
   input  logic              fifo_full,
   input  logic              dma_avail,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata
);
   generate
      if (CNT_W < 2 || CNT_W > 64) begin : g_bad_width
         $error("rx_ovr_stats: CNT_W must be within 2..64");
      end
      if (NUM_CNT > (1 << ADDR_W)) begin : g_bad_map
         $error("rx_ovr_stats: address space too small for counters");
      end
   endgenerate

   logic unused_inputs;
   assign unused_inputs = ^{frm_err, reg_wdata};

   ovr_inc_t          inc;
   logic [NUM_CNT-1:0] inc_v;
   logic [NUM_CNT-1:0] clr;
   logic [CNT_W-1:0]  cnt [NUM_CNT];

   rx_ovr_tracker i_tracker (
      .clk       (clk),
      .rst_n     (rst_n),
      .frm_sof   (frm_sof),
      .frm_eof   (frm_eof),
      .frm_match (frm_match),
      .fifo_full (fifo_full),
      .dma_avail (dma_avail),
      .inc       (inc)
   );

   always_comb begin
      inc_v          = '0;
      inc_v[IDX_SOF] = inc.sof;
      inc_v[IDX_MOF] = inc.mof;
      inc_v[IDX_DMA] = inc.dma;
   end

   genvar g;
   generate
      for (g = 0; g < NUM_CNT; g++) begin : g_cnt
         rx_ovr_counter #(.CNT_W(CNT_W)) i_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_v[g]),
            .clr   (clr[g]),
            .q     (cnt[g])
         );
      end
   endgenerate

   rx_ovr_regport #(.CNT_W(CNT_W), .RD_REG(RD_REG)) i_regport (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .cnt       (cnt),
      .clr       (clr),
      .reg_rdata (reg_rdata)
   );

   AST_NO_DOUBLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(inc_v[IDX_MOF:IDX_SOF]) <= 1); // R4
endmodule

// File: tb/test_rx_ovr_stats.sv
module test_rx_ovr_stats;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         frm_sof = 1'b0, frm_eof = 1'b0, frm_match = 1'b0;
   logic [2:0]   frm_err = '0;
   logic         fifo_full = 1'b0, dma_avail = 1'b1;
   logic [1:0]   reg_addr = '0;
   logic         reg_wr = 1'b0;
   logic [W-1:0] reg_wdata = '0;
   logic [W-1:0] reg_rdata;

   int n_run = 0, n_fail = 0;
   int exp_s = 0, exp_m = 0, exp_d = 0;

   always #10 clk = ~clk;

   rx_ovr_stats #(.CNT_W(W), .RD_REG(1'b0)) i_rx_ovr_stats (
      .clk(clk), .rst_n(rst_n), .frm_sof(frm_sof), .frm_eof(frm_eof),
      .frm_match(frm_match), .frm_err(frm_err), .fifo_full(fifo_full),
      .dma_avail(dma_avail), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   typedef struct packed {
      logic       match;
      logic       s_full;
      logic       s_dok;
      logic [7:0] mid;
      logic       m_full;
      logic       m_dok;
      logic [2:0] err;
      logic [7:0] len;
      logic       e_s;
      logic       e_m;
      logic       e_d;
   } vec_t;

   localparam vec_t VECS [13] = '{
      '{1'b1,1'b0,1'b1, 8'd0, 1'b0,1'b1, 3'd0, 8'd5,  1'b0,1'b0,1'b0}, // R8 clean
      '{1'b1,1'b1,1'b1, 8'd0, 1'b0,1'b1, 3'd0, 8'd4,  1'b1,1'b0,1'b0}, // R3 fifo
      '{1'b1,1'b0,1'b0, 8'd0, 1'b0,1'b1, 3'd0, 8'd4,  1'b1,1'b0,1'b1}, // R3 R5 dma
      '{1'b1,1'b1,1'b0, 8'd0, 1'b0,1'b1, 3'd0, 8'd3,  1'b1,1'b0,1'b1}, // R6
      '{1'b1,1'b0,1'b1, 8'd2, 1'b1,1'b1, 3'd0, 8'd6,  1'b0,1'b1,1'b0}, // R4
      '{1'b1,1'b0,1'b1, 8'd3, 1'b0,1'b0, 3'd0, 8'd6,  1'b0,1'b1,1'b1}, // R5 mid dma
      '{1'b1,1'b0,1'b1, 8'd4, 1'b1,1'b1, 3'd0, 8'd5,  1'b0,1'b1,1'b0}, // R4 at end
      '{1'b0,1'b1,1'b1, 8'd0, 1'b0,1'b1, 3'd0, 8'd4,  1'b0,1'b0,1'b0}, // R2
      '{1'b0,1'b0,1'b1, 8'd2, 1'b0,1'b0, 3'd0, 8'd4,  1'b0,1'b0,1'b0}, // R2
      '{1'b1,1'b1,1'b1, 8'd2, 1'b0,1'b0, 3'd0, 8'd4,  1'b1,1'b0,1'b0}, // R4 R5 first cause
      '{1'b1,1'b0,1'b0, 8'd0, 1'b0,1'b1, 3'd7, 8'd2,  1'b1,1'b0,1'b1}, // R7
      '{1'b1,1'b0,1'b1, 8'd30,1'b1,1'b1, 3'd1, 8'd40, 1'b0,1'b1,1'b0}, // R7 long
      '{1'b1,1'b1,1'b1, 8'd0, 1'b0,1'b1, 3'd0, 8'd1,  1'b1,1'b0,1'b0}  // R11 one-cycle
   };

   task automatic check(input string req, input logic [W-1:0] act, input int exp);
      n_run++;
      if (act !== W'(exp)) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, W'(exp));
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic check_all(input string req);
      logic [W-1:0] v;
      rd(2'd0, v); check({req, " sof"}, v, exp_s);
      rd(2'd1, v); check({req, " mof"}, v, exp_m);
      rd(2'd2, v); check({req, " dma"}, v, exp_d);
   endtask

   task automatic clear(input logic [1:0] a);
      @(negedge clk);
      reg_addr = a; reg_wr = 1'b1; reg_wdata = W'(4'ha);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic frame(input vec_t v);
      for (int k = 0; k < int'(v.len); k++) begin
         @(negedge clk);
         frm_sof   = (k == 0);
         frm_eof   = (k == int'(v.len) - 1);
         frm_match = v.match;
         frm_err   = frm_eof ? v.err : 3'd0;
         if (k == 0) begin
            fifo_full = v.s_full; dma_avail = v.s_dok;
         end else if (k == int'(v.mid)) begin
            fifo_full = v.m_full; dma_avail = v.m_dok;
         end else begin
            fifo_full = 1'b0; dma_avail = 1'b1;
         end
      end
      @(negedge clk);
      frm_sof = 0; frm_eof = 0; frm_match = 0; frm_err = 0;
      fifo_full = 0; dma_avail = 1;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      logic [W-1:0] v;
      vec_t f;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_all("R1 reset");

      foreach (VECS[i]) begin
         frame(VECS[i]);
         exp_s += int'(VECS[i].e_s);
         exp_m += int'(VECS[i].e_m);
         exp_d += int'(VECS[i].e_d);
         check_all($sformatf("R3/R4/R5 vector %0d", i));
      end

      // R10 address 3 reads zero, writes clear
      rd(2'd3, v); check("R10 addr3", v, 0);
      clear(2'd0); clear(2'd1); clear(2'd2);
      exp_s = 0; exp_m = 0; exp_d = 0;
      check_all("R10 clear");

      // R9 wrap
      f = '{1'b1,1'b1,1'b1, 8'd0, 1'b0,1'b1, 3'd0, 8'd1, 1'b1,1'b0,1'b0};
      for (int i = 0; i < 15; i++) frame(f);
      rd(2'd0, v); check("R9 all ones", v, 15);
      frame(f);
      rd(2'd0, v); check("R9 wrap", v, 0);

      // R10 clear beats increment in the same cycle
      frame(f);
      @(negedge clk);
      frm_sof = 1; frm_eof = 1; frm_match = 1; fifo_full = 1;
      reg_addr = 2'd0; reg_wr = 1;
      @(negedge clk);
      frm_sof = 0; frm_eof = 0; frm_match = 0; fifo_full = 0; reg_wr = 0;
      rd(2'd0, v); check("R10 clear priority", v, 0);

      // R11 restart drops the open frame
      @(negedge clk);
      frm_sof = 1; frm_match = 1;
      @(negedge clk);
      frm_sof = 0; fifo_full = 1;
      @(negedge clk);
      fifo_full = 0;
      @(negedge clk);
      frm_sof = 1;
      @(negedge clk);
      frm_sof = 0;
      @(negedge clk);
      frm_eof = 1;
      @(negedge clk);
      frm_eof = 0; frm_match = 0;
      check_all("R11 abort");

      // R12 stray end strobe
      @(negedge clk);
      frm_eof = 1; frm_match = 1; fifo_full = 1; dma_avail = 0;
      @(negedge clk);
      frm_eof = 0; frm_match = 0; fifo_full = 0; dma_avail = 1;
      check_all("R12 stray eof");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule